// File: doc/BRIEF.md
# Serial Peripheral Master with Divided Bit Clock

This block drives one serial peripheral as bus master. It produces its own serial clock from the core clock by a programmable divider. The serial clock period is one plus the programmed divide value, in core cycles. When the divide value is odd, the high and low phases are equal. When it is even, the high phase is one cycle longer than the low phase. A divide value of zero gives one core cycle high and one core cycle low. The serial clock rests low, and it toggles only while a transfer is in progress.

A one-cycle start request latches the parallel transmit word and the divide value. The block then pulls its active-low select line down and holds the clock low for one low phase. After that it runs one clock pulse per bit, sending the most significant bit first. It presents a new bit after each rising edge and samples the receive line on each falling edge. After the last falling edge it waits one more low phase, then raises select and removes its output enable. At the chip edge, that output enable puts the transmit pad into high impedance. In the same cycle, a one-cycle done pulse marks the parallel receive word as valid.

Top module: `spi_master_gen`

## Requirements
- R1: For a nonzero divide value DIV, one serial clock high phase plus one low phase lasts exactly 1 + DIV core cycles.
- R2: For an even nonzero DIV, the high phase lasts DIV/2 + 1 core cycles and the low phase lasts DIV/2 core cycles.
- R3: For an odd DIV, the high phase and the low phase each last (DIV + 1)/2 core cycles.
- R4: For DIV = 0, the high phase and the low phase each last one core cycle.
- R5: Select goes low in the cycle after an accepted start. The serial clock then stays low for one low phase before its first rising edge. The serial clock is low whenever select is high.
- R6: Bits are sent most significant first. The MSB is on `mosiOut` from the first cycle that select is low. Bit WORD_W-k is on the line from the k-th rising edge onward, so the line changes only at rising edges. Each transfer has exactly WORD_W rising edges.
- R7: `miso` is sampled at the core edge on which the serial clock falls. The first sampled bit lands in the MSB of `rxWord`.
- R8: After the last falling edge, select stays low for one more low phase and then goes high. `mosiOe` is 1 exactly while select is low; when it is 0, the transmit pad is high impedance.
- R9: `doneP` is high for exactly one cycle: the first cycle in which select is high again. `rxWord` holds the received word from then until the next done pulse.
- R10: A start request that arrives while a transfer is active is ignored, including in the cycle in which select is released. The divide value and transmit word are latched at acceptance, so later changes to them have no effect on the transfer.
- R11: Out of reset, select is high, the serial clock is low, `mosiOe` is 0 and `doneP` is 0.
- R12: If the start request is held high, the next transfer begins with select high for exactly one cycle between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divVal | input | DIV_W | Divide value DIV, latched at start |
| startReq | input | 1 | Start request, taken only when idle |
| txWord | input | WORD_W | Word to send, latched at start |
| miso | input | 1 | Serial receive line |
| sclk | output | 1 | Serial clock, rests low |
| selN | output | 1 | Active-low slave select |
| mosiOut | output | 1 | Serial transmit data |
| mosiOe | output | 1 | Transmit pad enable; 0 means high impedance |
| rxWord | output | WORD_W | Received word, valid with `doneP` |
| doneP | output | 1 | One-cycle transfer-complete pulse |

## Verification
A start request and the completion of the previous transfer can fall on the same core edge. At that edge the control is still in its final low phase, so the request must be ignored. It must then be taken on the next edge. The bench provokes this by holding the start request high across two transfers. It then checks three things: select stays high for exactly one cycle between the transfers, exactly one done pulse appears per transfer, and each received word is correct. A second start pulse in the middle of a transfer, with a changed transmit word and divide value, must leave the bit pattern, the phase lengths and the transfer count unchanged.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } spiState_t;

  typedef struct packed {
    logic load;     // latch transmit word at acceptance
    logic shiftTx;  // advance to next transmit bit (rising edge, not first)
    logic sample;   // capture receive line (falling edge)
    logic finish;   // transfer complete, publish receive word
  } spiStrb_t;

endpackage

// File: rtl/spi_phase_calc.sv
module spi_phase_calc #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] divVal,
  output logic [DIV_W-1:0] highLen,
  output logic [DIV_W-1:0] lowLen
);

  localparam logic [DIV_W-1:0] ONE_D = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W:0]   roundedHalf;
  logic [DIV_W-1:0] floorHalf;

  assign roundedHalf = ({1'b0, divVal} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
  assign floorHalf   = divVal >> 1;

  always_comb begin
    if (divVal == '0) begin
      highLen = ONE_D;
      lowLen  = ONE_D;
    end else if (divVal[0]) begin
      highLen = roundedHalf[DIV_W-1:0];
      lowLen  = roundedHalf[DIV_W-1:0];
    end else begin
      highLen = floorHalf + ONE_D;
      lowLen  = floorHalf;
    end
  end

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] divVal,
  output logic             sclk,
  output logic             selN,
  output logic             mosiOe,
  output logic             doneP,
  output spiStrb_t         strb
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] BITS_ALL = CNT_W'(WORD_W);
  localparam logic [DIV_W-1:0] ONE_D = {{(DIV_W-1){1'b0}}, 1'b1};

  spiState_t        state;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] phaseCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] highLen;
  logic [DIV_W-1:0] lowLen;
  logic             phaseEnd;
  logic             lastBit;
  logic             accept;

  spi_phase_calc #(.DIV_W(DIV_W)) u_phase (
    .divVal (divReg),
    .highLen(highLen),
    .lowLen (lowLen)
  );

  always_comb begin
    case (state)
      ST_LEAD: phaseEnd = (phaseCnt == lowLen - ONE_D);
      ST_HIGH: phaseEnd = (phaseCnt == highLen - ONE_D);
      ST_LOW:  phaseEnd = (phaseCnt == lowLen - ONE_D);
      default: phaseEnd = 1'b0;
    endcase
  end

  assign lastBit = (bitCnt == BITS_ALL);
  assign accept  = (state == ST_IDLE) && startReq;

  always_comb begin
    strb.load    = accept;
    strb.shiftTx = (state == ST_LOW) && phaseEnd && !lastBit;
    strb.sample  = (state == ST_HIGH) && phaseEnd;
    strb.finish  = (state == ST_LOW) && phaseEnd && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divReg   <= '0;
      phaseCnt <= '0;
      bitCnt   <= '0;
      sclk     <= 1'b0;
      selN     <= 1'b1;
      mosiOe   <= 1'b0;
      doneP    <= 1'b0;
    end else begin
      doneP <= strb.finish;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_LEAD;
            divReg   <= divVal;
            phaseCnt <= '0;
            bitCnt   <= '0;
            selN     <= 1'b0;
            mosiOe   <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (phaseEnd) begin
            state    <= ST_HIGH;
            phaseCnt <= '0;
            sclk     <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + ONE_D;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            state    <= ST_LOW;
            phaseCnt <= '0;
            sclk     <= 1'b0;
            bitCnt   <= bitCnt + 1'b1;
          end else begin
            phaseCnt <= phaseCnt + ONE_D;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (lastBit) begin
              state  <= ST_IDLE;
              selN   <= 1'b1;
              mosiOe <= 1'b0;
            end else begin
              state <= ST_HIGH;
              sclk  <= 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + ONE_D;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !selN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (selN && !mosiOe && !sclk));

  // R10
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(divReg));

  // R8
  release_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selN) |-> (!sclk && !$past(sclk)));

endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrb_t          strb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosiOut,
  output logic [WORD_W-1:0] rxWord
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (strb.load)
        txShift <= txWord;
      else if (strb.shiftTx)
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (strb.sample)
        rxShift <= {rxShift[WORD_W-2:0], miso};
      if (strb.finish)
        rxWord <= rxShift;
    end
  end

  assign mosiOut = txShift[WORD_W-1];

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(rxWord));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.shiftTx) |=> $stable(mosiOut));

endmodule

// File: rtl/spi_master_gen.sv
module spi_master_gen
  import spi_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              startReq,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              sclk,
  output logic              selN,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic [WORD_W-1:0] rxWord,
  output logic              doneP
);

  spiStrb_t strb;

  spi_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .divVal  (divVal),
    .sclk    (sclk),
    .selN    (selN),
    .mosiOe  (mosiOe),
    .doneP   (doneP),
    .strb    (strb)
  );

  spi_datapath #(.WORD_W(WORD_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .txWord (txWord),
    .miso   (miso),
    .mosiOut(mosiOut),
    .rxWord (rxWord)
  );

endmodule

// File: tb/spi_master_gen_bench.sv
module spi_master_gen_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   divVal = '0;
  logic         startReq = 1'b0;
  logic [W-1:0] txWord = '0;
  logic         miso = 1'b0;
  logic         sclk, selN, mosiOut, mosiOe, doneP;
  logic [W-1:0] rxWord;

  spi_master_gen #(.WORD_W(W), .DIV_W(8)) u_spi_master_gen (
    .clk(clk), .rstN(rstN), .divVal(divVal), .startReq(startReq),
    .txWord(txWord), .miso(miso), .sclk(sclk), .selN(selN),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .rxWord(rxWord), .doneP(doneP)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;

  // monitor state
  logic [W-1:0] curTx = '0, curRx = '0, rxAtDone = '0;
  int expHi = 1, expLo = 1;
  int xferCnt = 0, doneCnt = 0, riseCnt = 0, runLen = 0, gapLen = 0, gapSeen = 0;
  int leadErr = 0, hiErr = 0, loErr = 0, tailErr = 0, mosiErr = 0;
  int oeErr = 0, doneErr = 0, idleErr = 0, lastHi = 0, lastLo = 0;
  logic prevS = 1'b0, prevSel = 1'b1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (selN && sclk) idleErr++;
      if (selN == mosiOe) oeErr++;
      if (doneP) begin
        doneCnt++;
        rxAtDone = rxWord;
        if (!(selN && !prevSel)) doneErr++;
      end else if (selN && !prevSel) doneErr++;
      if (!selN && prevSel) begin
        xferCnt++;
        riseCnt = 0;
        runLen = 1;
        gapSeen = gapLen;
        if (mosiOut !== curTx[W-1]) mosiErr++;
      end else if (!selN) begin
        if (sclk && !prevS) begin
          riseCnt++;
          if (riseCnt == 1) begin
            if (runLen != expLo) leadErr++;
          end else begin
            if (runLen != expLo) loErr++;
            lastLo = runLen;
          end
          if (riseCnt <= W) begin
            if (mosiOut !== curTx[W-riseCnt]) mosiErr++;
            miso = curRx[W-riseCnt];
          end
          runLen = 1;
        end else if (!sclk && prevS) begin
          if (runLen != expHi) hiErr++;
          lastHi = runLen;
          runLen = 1;
        end else begin
          if (riseCnt >= 1 && riseCnt <= W && mosiOut !== curTx[W-riseCnt]) mosiErr++;
          runLen++;
        end
      end else if (selN && !prevSel) begin
        if (runLen != expLo) tailErr++;
        gapLen = 1;
      end else begin
        gapLen++;
      end
      prevS = sclk;
      prevSel = selN;
    end
  end

  function automatic string divReq(int d);
    if (d == 0) return "R4";
    if (d % 2 == 1) return "R3";
    return "R2";
  endfunction

  task automatic setExpect(int d, logic [W-1:0] tx, logic [W-1:0] rx);
    curTx = tx; curRx = rx;
    if (d == 0) begin expHi = 1; expLo = 1; end
    else if (d % 2 == 1) begin expHi = (d + 1) / 2; expLo = (d + 1) / 2; end
    else begin expHi = d / 2 + 1; expLo = d / 2; end
    leadErr = 0; hiErr = 0; loErr = 0; tailErr = 0; mosiErr = 0;
    oeErr = 0; doneErr = 0; idleErr = 0;
  endtask

  task automatic judge(int d, logic [W-1:0] rx, int dDone, int dXfer);
    chk(leadErr == 0, "R5", "lead phase errors", leadErr, 0);
    chk(idleErr == 0, "R5", "clock while deselected", idleErr, 0);
    chk(hiErr == 0, divReq(d), "high phase errors", hiErr, 0);
    chk(loErr == 0, divReq(d), "low phase errors", loErr, 0);
    if (d > 0) chk(lastHi + lastLo == d + 1, "R1", "period", lastHi + lastLo, d + 1);
    chk(mosiErr == 0, "R6", "transmit bit errors", mosiErr, 0);
    chk(riseCnt == W, "R6", "rising edges", riseCnt, W);
    chk(rxAtDone == rx, "R7", "received word", rxAtDone, rx);
    chk(tailErr == 0, "R8", "tail phase errors", tailErr, 0);
    chk(oeErr == 0, "R8", "output enable errors", oeErr, 0);
    chk(doneErr == 0, "R9", "done placement errors", doneErr, 0);
    chk(dDone == 1, "R9", "done pulses", dDone, 1);
    chk(dXfer == 1, "R10", "transfers started", dXfer, 1);
  endtask

  task automatic runXfer(int d, logic [W-1:0] tx, logic [W-1:0] rx, bit interfere);
    int baseX, baseD;
    @(posedge clk);
    setExpect(d, tx, rx);
    baseX = xferCnt; baseD = doneCnt;
    @(negedge clk);
    divVal = 8'(d); txWord = tx; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (interfere) begin
      repeat (3) @(negedge clk);
      txWord = ~tx; divVal = 8'(d + 3); startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (doneCnt == baseD) @(posedge clk);
    repeat (2 * (d + 2) + 4) @(negedge clk);
    @(posedge clk);
    judge(d, rx, doneCnt - baseD, xferCnt - baseX);
    if (interfere)
      chk(rxWord == rx, "R9", "receive word held", rxWord, rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(selN == 1'b1, "R11", "selN", selN, 1);
    chk(sclk == 1'b0, "R11", "sclk", sclk, 0);
    chk(mosiOe == 1'b0, "R11", "mosiOe", mosiOe, 0);
    chk(doneP == 1'b0, "R11", "doneP", doneP, 0);

    runXfer(0, 8'h80, 8'h01, 1'b0);
    runXfer(0, 8'hFF, 8'h00, 1'b0);
    runXfer(0, 8'h00, 8'hFF, 1'b0);
    for (int d = 0; d <= 12; d++)
      for (int p = 0; p < 3; p++)
        runXfer(d, 8'(d * 29 + p * 83 + 17), 8'((d * 53) ^ (p * 151) ^ 8'h5A), 1'b0);
    runXfer(127, 8'hA5, 8'h3C, 1'b0);
    runXfer(128, 8'h5A, 8'hC3, 1'b0);
    runXfer(254, 8'h96, 8'h69, 1'b0);
    runXfer(255, 8'h0F, 8'hF0, 1'b0);

    // R10: start, word and divide changes during a transfer
    runXfer(2, 8'hB4, 8'h2D, 1'b1);
    runXfer(5, 8'h71, 8'h8E, 1'b1);

    // R12: start held high across two transfers
    begin
      int baseX, baseD;
      @(posedge clk);
      setExpect(3, 8'hC6, 8'h39);
      baseX = xferCnt; baseD = doneCnt;
      @(negedge clk);
      divVal = 8'd3; txWord = 8'hC6; startReq = 1'b1;
      while (xferCnt < baseX + 2) @(posedge clk);
      @(negedge clk);
      startReq = 1'b0;
      chk(gapSeen == 1, "R12", "select high gap", gapSeen, 1);
      chk(rxAtDone == 8'h39, "R12", "first received word", rxAtDone, 8'h39);
      while (doneCnt < baseD + 2) @(posedge clk);
      repeat (12) @(negedge clk);
      @(posedge clk);
      chk(doneCnt - baseD == 2, "R12", "done pulses", doneCnt - baseD, 2);
      chk(xferCnt - baseX == 2, "R10", "transfers with held start", xferCnt - baseX, 2);
      chk(rxAtDone == 8'h39, "R7", "second received word", rxAtDone, 8'h39);
      chk(mosiErr == 0 && doneErr == 0, "R9", "back-to-back errors", mosiErr + doneErr, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule